// File: doc/BRIEF.md
# Keyed Virtual Address Rotator

This block sits in the address-generation path. It scrambles a 64-bit virtual address with a circular rotation whose amount is a per-process secret. The point is to hide how program addresses map onto cache sets. Only the page-number field, bits 63:12, is rotated. The page-offset field, bits 11:0, passes through untouched, so the virtual-memory page contract is kept. The rotation is done by a logarithmic barrel rotator in a single combinational step.

A small key register holds the rotate amount. The operating system reloads it on each context switch through a write strobe. The field is 52 bits wide, which is not a power of two, so the 6-bit key is reduced modulo 52 when it is loaded. The block also gives the inverse rotation of the same input: the opposite direction by the same amount. A scrambled address can therefore be mapped back, and a forward-then-inverse round trip returns the original address.

Top module: `vaddr_rotator`

## Requirements
- R1: Bits 11:0 of both `vaddr_fwd` and `vaddr_inv` always equal bits 11:0 of `vaddr_in`.
- R2: With effective amount k, `vaddr_fwd` holds the field bits 63:12 rotated toward the MSB by k within the 52-bit field. Field bit i of the input appears at field bit (i+k) mod 52 of the output.
- R3: `vaddr_inv` holds the field rotated toward the LSB by k. Field bit j of the output is field bit (j+k) mod 52 of the input.
- R4: Driving `vaddr_in` with the forward image of an address A under key k makes `vaddr_inv` equal A.
- R5: A synchronous active-low reset clears the key to 0. With key 0, both outputs equal `vaddr_in`.
- R6: On a rising clock edge with `key_wr_en` high, the key loads from `key_wr_val`. The new key is used from that edge on. Before that edge the old key applies. With `key_wr_en` low, `key_wr_val` has no effect.
- R7: A written key value of 52 to 63 acts as that value minus 52. For example, 52 acts as 0 and 63 acts as 11.
- R8: Both outputs follow `vaddr_in` combinationally, within the same clock cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the key register |
| rst_n | input | 1 | Synchronous reset, active low; clears the key |
| key_wr_en | input | 1 | Load strobe for the rotation key |
| key_wr_val | input | 6 | New rotation key, raw value 0..63 |
| vaddr_in | input | 64 | Virtual address to transform |
| vaddr_fwd | output | 64 | Address with the page-number field rotated toward the MSB |
| vaddr_inv | output | 64 | Address with the page-number field rotated toward the LSB |

## Verification
A corrupted key register shows at once, in the first cycle after the faulty load. Every address then lands on the wrong rotation, and a round trip through the forward image no longer returns the original. A wrong modulo reduction only shows when a key of 52 or more is written. For that reason every raw key value is written and checked against a fresh address. A broken barrel stage only shows for amounts that set its amount bit. A rotation that leaks into the offset shows in bits 11:0 on the first address whose top field is non-zero.

// File: rtl/varot_pkg.sv
package varot_pkg;

  typedef enum logic {
    ROT_LEFT  = 1'b0,
    ROT_RIGHT = 1'b1
  } rot_dir_e;

  // Reduce a raw key into the range 0 .. width-1.
  function automatic int unsigned wrap_amount(input int unsigned raw, input int unsigned width);
    return raw % width;
  endfunction

  // Distance moved by barrel stage s inside a field of the given width.
  function automatic int unsigned stage_span(input int unsigned s, input int unsigned width);
    return (32'd1 << s) % width;
  endfunction

endpackage

// File: rtl/vrot_key_reg.sv
module vrot_key_reg #(
  parameter int FIELD_W = 52,
  parameter int AMT_W   = $clog2(FIELD_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AMT_W-1:0] wr_key,
  output logic [AMT_W-1:0] amt_o
);

  localparam logic [AMT_W-1:0] FIELD_K = AMT_W'(FIELD_W);

  logic             key_load;
  logic [AMT_W-1:0] amt_next;

  assign key_load = wr_en;
  assign amt_next = AMT_W'(varot_pkg::wrap_amount(32'(wr_key), 32'(FIELD_W)));

  always_ff @(posedge clk) begin
    if (!rst_n)        amt_o <= '0;
    else if (key_load) amt_o <= amt_next;
  end

  AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !key_load |=> $stable(amt_o)); // R6
  AST_KEY_LOAD_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    (key_load && wr_key < FIELD_K) |=> amt_o == $past(wr_key)); // R6
  AST_KEY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (key_load && wr_key >= FIELD_K) |=> amt_o == AMT_W'($past(wr_key) - FIELD_K)); // R7
  AST_KEY_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    amt_o < FIELD_K); // R7

endmodule

// File: rtl/vrot_barrel.sv
module vrot_barrel #(
  parameter int                  W     = 52,
  parameter int                  AMT_W = $clog2(W),
  parameter varot_pkg::rot_dir_e DIR   = varot_pkg::ROT_LEFT
) (
  input  logic [W-1:0]     data_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [W-1:0]     data_o
);

  logic [W-1:0] stg [AMT_W+1];

  assign stg[0] = data_i;

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int SP = int'(varot_pkg::stage_span(s, W));
    logic [W-1:0] moved;
    if (DIR == varot_pkg::ROT_LEFT) begin : g_left
      assign moved = {stg[s][W-1-SP:0], stg[s][W-1:W-SP]};
    end else begin : g_right
      assign moved = {stg[s][SP-1:0], stg[s][W-1:SP]};
    end
    assign stg[s+1] = amt_i[s] ? moved : stg[s];
  end

  assign data_o = stg[AMT_W];

endmodule

// File: rtl/vaddr_rotator.sv
module vaddr_rotator #(
  parameter int ADDR_W = 64,
  parameter int OFFS_W = 12,
  localparam int FIELD_W = ADDR_W - OFFS_W,
  localparam int KEY_W   = $clog2(FIELD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr_en,
  input  logic [KEY_W-1:0]  key_wr_val,
  input  logic [ADDR_W-1:0] vaddr_in,
  output logic [ADDR_W-1:0] vaddr_fwd,
  output logic [ADDR_W-1:0] vaddr_inv
);

  logic [KEY_W-1:0]   rot_amt;
  logic [FIELD_W-1:0] in_field;
  logic [FIELD_W-1:0] fwd_field;
  logic [FIELD_W-1:0] inv_field;
  logic [OFFS_W-1:0]  page_off;

  assign in_field = vaddr_in[ADDR_W-1:OFFS_W];
  assign page_off = vaddr_in[OFFS_W-1:0];

  vrot_key_reg #(.FIELD_W(FIELD_W), .AMT_W(KEY_W)) u_key (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (key_wr_en),
    .wr_key(key_wr_val),
    .amt_o (rot_amt)
  );

  vrot_barrel #(.W(FIELD_W), .AMT_W(KEY_W), .DIR(varot_pkg::ROT_LEFT)) u_fwd (
    .data_i(in_field),
    .amt_i (rot_amt),
    .data_o(fwd_field)
  );

  vrot_barrel #(.W(FIELD_W), .AMT_W(KEY_W), .DIR(varot_pkg::ROT_RIGHT)) u_inv (
    .data_i(in_field),
    .amt_i (rot_amt),
    .data_o(inv_field)
  );

  assign vaddr_fwd = {fwd_field, page_off};
  assign vaddr_inv = {inv_field, page_off};

  AST_FWD_POPCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fwd_field) == $countones(in_field)); // R2
  AST_INV_POPCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(inv_field) == $countones(in_field)); // R3
  AST_FWD_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_amt == KEY_W'(1)) |-> fwd_field == {in_field[FIELD_W-2:0], in_field[FIELD_W-1]}); // R2
  AST_INV_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_amt == KEY_W'(1)) |-> inv_field == {in_field[0], in_field[FIELD_W-1:1]}); // R3
  AST_ZERO_KEY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_amt == '0) |-> (vaddr_fwd == vaddr_in && vaddr_inv == vaddr_in)); // R5

endmodule

// File: tb/vaddr_rotator_bench.sv
module vaddr_rotator_bench;

  localparam int CLK_PERIOD = 10;
  localparam int FW = 52;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        key_wr_en = 1'b0;
  logic [5:0]  key_wr_val = '0;
  logic [63:0] vaddr_in = '0;
  logic [63:0] vaddr_fwd;
  logic [63:0] vaddr_inv;

  int checks = 0;
  int failures = 0;
  int model_key = 0;
  bit finished = 0;

  typedef struct {
    logic [63:0] addr;
    logic [63:0] fwd;
    logic [63:0] inv;
    string       tag;
  } item_t;

  item_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vaddr_rotator u_vaddr_rotator (
    .clk       (clk),
    .rst_n     (rst_n),
    .key_wr_en (key_wr_en),
    .key_wr_val(key_wr_val),
    .vaddr_in  (vaddr_in),
    .vaddr_fwd (vaddr_fwd),
    .vaddr_inv (vaddr_inv)
  );

  // Model: output field bit (i+k) mod 52 takes input field bit i.
  function automatic logic [63:0] model_fwd(input logic [63:0] a, input int k);
    logic [63:0] r;
    r = a;
    for (int i = 0; i < FW; i++) r[12 + ((i + k) % FW)] = a[12 + i];
    return r;
  endfunction

  // Model: output field bit j takes input field bit (j+k) mod 52.
  function automatic logic [63:0] model_inv(input logic [63:0] a, input int k);
    logic [63:0] r;
    r = a;
    for (int j = 0; j < FW; j++) r[12 + j] = a[12 + ((j + k) % FW)];
    return r;
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [63:0] a, input string tag);
    item_t it;
    it.addr = a;
    it.fwd  = model_fwd(a, model_key);
    it.inv  = model_inv(a, model_key);
    it.tag  = tag;
    sbq.push_back(it);
  endtask

  task automatic apply(input logic [63:0] a, input string tag);
    @(posedge clk); #1;
    vaddr_in = a;
    push(a, tag);
  endtask

  // Key takes effect at the edge that samples the strobe (R6).
  task automatic write_key(input int k, input string tag);
    @(posedge clk); #1;
    key_wr_en  = 1'b1;
    key_wr_val = 6'(k);
    vaddr_in   = rnd64();
    push(vaddr_in, "R6 old key before edge");
    @(posedge clk); #1;
    key_wr_en  = 1'b0;
    key_wr_val = 6'($urandom());
    model_key  = k % FW;
    vaddr_in   = rnd64();
    push(vaddr_in, tag);
  endtask

  // Monitor: compares the oldest expected item in the same cycle (R8).
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      check({"R1 offset fwd ", it.tag}, {52'd0, vaddr_fwd[11:0]}, {52'd0, it.addr[11:0]});
      check({"R1 offset inv ", it.tag}, {52'd0, vaddr_inv[11:0]}, {52'd0, it.addr[11:0]});
      check({"R2 fwd ", it.tag}, vaddr_fwd, it.fwd);
      check({"R3 inv ", it.tag}, vaddr_inv, it.inv);
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [63:0] a;
    logic [63:0] img;
    // R5: reset holds the key at zero, outputs pass through.
    apply(64'hFEDC_BA98_7654_3210, "R5 in reset");
    apply(64'hFFFF_FFFF_FFFF_F000, "R5 in reset");
    @(posedge clk); #1 rst_n = 1'b1;
    apply(64'h8000_0000_0000_0ABC, "R5 after reset");

    // R6: strobe low leaves the key untouched.
    key_wr_val = 6'd17;
    apply(64'h0000_0000_0000_1000, "R6 strobe low");
    apply(rnd64(), "R6 strobe low");

    // R2/R3: single-bit and pattern cases.
    write_key(1, "R2 key1");
    apply(64'h8000_0000_0000_0000, "R2 msb wraps");
    apply(64'h0000_0000_0000_1FFF, "R2 lsb of field");
    write_key(51, "R3 key51");
    apply(64'h0000_0000_0000_1000, "R3 key51 lsb");
    apply(64'hA5A5_A5A5_A5A5_A5A5, "R3 key51 pattern");

    // R7 and R2/R3: every raw key value.
    for (int k = 0; k < 64; k++) begin
      write_key(k, (k >= FW) ? "R7 wrapped key" : "R2 sweep");
      apply(rnd64(), "R3 sweep");
    end

    // R4: round trip through the forward image.
    for (int n = 0; n < 8; n++) begin
      write_key(n * 7 + 3, "R4 key");
      a   = rnd64();
      img = model_fwd(a, model_key);
      @(posedge clk); #1;
      vaddr_in = img;
      #2 check("R4 round trip", vaddr_inv, a);
    end

    // R8: outputs follow a mid-cycle change without a clock edge.
    write_key(20, "R8 key");
    @(posedge clk); #2;
    a = rnd64();
    vaddr_in = a;
    #1 check("R8 comb fwd", vaddr_fwd, model_fwd(a, 20));
    check("R8 comb inv", vaddr_inv, model_inv(a, 20));

    // R5: reset mid-run clears a non-zero key.
    @(posedge clk); #1 rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    model_key = 0;
    vaddr_in = 64'h1234_5678_9ABC_DEF0;
    push(vaddr_in, "R5 reset clears key");

    @(posedge clk);
    @(posedge clk);
    summary();
  end

endmodule